// File: doc/BRIEF.md
# Word Address Counter with Page Wrap

This block keeps the current 15-bit word address of a 32K-byte serial memory. A protocol engine loads the address in two byte-wide strokes: first the upper part, then the lower part. The counter then supplies the address for every array access. After each transferred byte the engine pulses a step input, and the counter moves to the next address.

A mode input selects how a step behaves. In write mode only the 6-bit offset inside a 64-byte page counts, so a long burst folds back onto the start of the same page. In read mode the whole 15-bit value counts and wraps from the last address to zero. Between transactions the counter simply holds its value. A later read with no address phase therefore starts at the byte after the last one accessed.

Each cycle the decoder picks exactly one operation from the strobes, in fixed priority. The operations are OP_HOLD, OP_SET_HI, OP_SET_LO, OP_STEP_PAGE and OP_STEP_FULL. The address register always moves to the value that the selected operation produces.

Top module: `word_addr_ctr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `word_addr` becomes 0.
- R2: A `hi_load` pulse copies `addr_byte[6:0]` into `word_addr[14:8]`. `addr_byte[7]` is ignored, so bit 14 follows `addr_byte[6]`. `word_addr[7:0]` is unchanged.
- R3: A `lo_load` pulse copies `addr_byte[7:0]` into `word_addr[7:0]` and leaves `word_addr[14:8]` unchanged.
- R4: A `step` with `wr_mode`=1 adds one, modulo 64, to `word_addr[5:0]` and keeps `word_addr[14:6]` unchanged. Offset 63 goes back to offset 0 of the same page.
- R5: A `step` with `wr_mode`=0 adds one across all 15 bits. 0x7FFF goes to 0x0000.
- R6: When strobes coincide, `hi_load` wins over `lo_load`, and both loads win over `step`.
- R7: With no strobe asserted, `word_addr` holds its value for any number of cycles.
- R8: A read-mode step that follows a write burst and idle cycles continues from the held address, with no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_load | input | 1 | Load the upper address part from `addr_byte` |
| lo_load | input | 1 | Load the lower address byte from `addr_byte` |
| addr_byte | input | 8 | Address byte from the protocol engine |
| step | input | 1 | Advance after a transferred byte |
| wr_mode | input | 1 | 1: page-wrapping step, 0: full-range step |
| word_addr | output | 15 | Current word address |

## Verification
The bench builds the block with its default parameters: a 15-bit address, 8-bit bytes and a 6-bit page offset. With these values the page edge at offset 63 and the top-of-array wrap at 0x7FFF are reached with one load pair and a single step each. A run of random strobe combinations against the bench's own address model covers coinciding loads and steps in both modes.

// File: rtl/wac_pkg.sv
package wac_pkg;
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_SET_HI,
        OP_SET_LO,
        OP_STEP_PAGE,
        OP_STEP_FULL
    } wac_op_e;
endpackage

// File: rtl/wac_op_sel.sv
module wac_op_sel
    import wac_pkg::*;
(
    input  logic    hi_load,
    input  logic    lo_load,
    input  logic    step,
    input  logic    wr_mode,
    output wac_op_e op
);
    // Fixed priority: upper load, lower load, then step.
    always_comb begin
        if (hi_load)
            op = OP_SET_HI;
        else if (lo_load)
            op = OP_SET_LO;
        else if (step)
            op = wr_mode ? OP_STEP_PAGE : OP_STEP_FULL;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/wac_next.sv
module wac_next
    import wac_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BYTE_W = 8,
    parameter int PAGE_W = 6
) (
    input  wac_op_e            op,
    input  logic [ADDR_W-1:0]  cur,
    input  logic [BYTE_W-1:0]  byte_in,
    output logic [ADDR_W-1:0]  nxt
);
    localparam int HI_W = ADDR_W - BYTE_W;
    localparam logic [ADDR_W-1:0] A_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] inc_full;
    logic [ADDR_W-1:0] inc_page;
    logic [ADDR_W-1:0] set_hi;
    logic [ADDR_W-1:0] set_lo;
    logic              unused_byte_msbs;

    assign inc_full = cur + A_ONE;
    assign set_hi   = {byte_in[HI_W-1:0], cur[BYTE_W-1:0]};
    assign set_lo   = {cur[ADDR_W-1:BYTE_W], byte_in};
    assign unused_byte_msbs = ^byte_in[BYTE_W-1:HI_W];

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            assign inc_page = inc_full;
        end else begin : g_wrap
            localparam logic [PAGE_W-1:0] P_ONE = {{(PAGE_W-1){1'b0}}, 1'b1};
            logic [PAGE_W-1:0] off_nx;
            assign off_nx   = cur[PAGE_W-1:0] + P_ONE;
            assign inc_page = {cur[ADDR_W-1:PAGE_W], off_nx};
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_SET_HI:    nxt = set_hi;
            OP_SET_LO:    nxt = set_lo;
            OP_STEP_PAGE: nxt = inc_page;
            OP_STEP_FULL: nxt = inc_full;
            default:      nxt = cur;
        endcase
    end
endmodule

// File: rtl/word_addr_ctr.sv
module word_addr_ctr
    import wac_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BYTE_W = 8,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_load,
    input  logic              lo_load,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              step,
    input  logic              wr_mode,
    output logic [ADDR_W-1:0] word_addr
);
    wac_op_e           op;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;

    wac_op_sel u_sel (
        .hi_load (hi_load),
        .lo_load (lo_load),
        .step    (step),
        .wr_mode (wr_mode),
        .op      (op)
    );

    wac_next #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .PAGE_W (PAGE_W)
    ) u_next (
        .op      (op),
        .cur     (addr_q),
        .byte_in (addr_byte),
        .nxt     (addr_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else
            addr_q <= addr_d;
    end

    always_comb begin
        word_addr = addr_q;
    end
endmodule

// File: rtl/word_addr_ctr_chk.sv
module word_addr_ctr_chk #(
    parameter int ADDR_W = 15,
    parameter int BYTE_W = 8,
    parameter int PAGE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hi_load,
    input logic              lo_load,
    input logic [BYTE_W-1:0] addr_byte,
    input logic              step,
    input logic              wr_mode,
    input logic [ADDR_W-1:0] word_addr
);
    localparam int HI_W = ADDR_W - BYTE_W;

    AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        hi_load |=> (word_addr[ADDR_W-1:BYTE_W] == $past(addr_byte[HI_W-1:0]))
                 && (word_addr[BYTE_W-1:0] == $past(word_addr[BYTE_W-1:0]))); // R2

    AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_load && !hi_load) |=> (word_addr[BYTE_W-1:0] == $past(addr_byte))
                 && $stable(word_addr[ADDR_W-1:BYTE_W])); // R3

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wr_mode && !hi_load && !lo_load) |=>
            $stable(word_addr[ADDR_W-1:PAGE_W])
            && (word_addr[PAGE_W-1:0] == $past(word_addr[PAGE_W-1:0]) + 1'b1)); // R4

    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_mode && !hi_load && !lo_load) |=>
            (word_addr == $past(word_addr) + 1'b1)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !hi_load && !lo_load) |=> $stable(word_addr)); // R7
endmodule

bind word_addr_ctr word_addr_ctr_chk #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .PAGE_W (PAGE_W)
) u_chk (.*);

// File: tb/test_word_addr_ctr.sv
module test_word_addr_ctr;
    localparam int AW = 15;
    localparam int BW = 8;

    typedef struct {
        logic [AW-1:0] exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hi_load = 1'b0;
    logic          lo_load = 1'b0;
    logic [BW-1:0] addr_byte = '0;
    logic          step = 1'b0;
    logic          wr_mode = 1'b0;
    logic [AW-1:0] word_addr;

    int            n_run = 0;
    int            n_fail = 0;
    logic [AW-1:0] model = '0;
    item_t         sb[$];
    bit            done = 1'b0;

    always #5 clk = ~clk;

    word_addr_ctr i_word_addr_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_load   (hi_load),
        .lo_load   (lo_load),
        .addr_byte (addr_byte),
        .step      (step),
        .wr_mode   (wr_mode),
        .word_addr (word_addr)
    );

    // Reference model built from the requirements.
    function automatic logic [AW-1:0] ref_next(logic [AW-1:0] a, logic lh, logic ll,
                                               logic [BW-1:0] b, logic st, logic wm);
        logic [5:0] off;
        if (lh)      return {b[6:0], a[7:0]};                  // R2, R6
        else if (ll) return {a[14:8], b};                      // R3, R6
        else if (st) begin
            if (wm) begin off = a[5:0] + 6'd1; return {a[14:6], off}; end // R4
            else return a + 15'd1;                             // R5
        end
        return a;                                              // R7
    endfunction

    task automatic drive(input logic lh, input logic ll, input logic [BW-1:0] b,
                         input logic st, input logic wm, input string tag);
        item_t it;
        @(negedge clk);
        hi_load = lh; lo_load = ll; addr_byte = b; step = st; wr_mode = wm;
        model = ref_next(model, lh, ll, b, st, wm);
        it.exp = model; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_model(input logic [AW-1:0] v, input string tag);
        n_run++;
        if (model !== v) begin
            n_fail++;
            $display("FAIL %s model actual=%h expected=%h", tag, model, v);
        end
    endtask

    // Monitor: compare each result just after the edge that produces it.
    always begin
        @(posedge clk);
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_run++;
            if (word_addr !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, word_addr, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if (word_addr !== 15'h0000) begin
            n_fail++;
            $display("FAIL R1 actual=%h expected=%h", word_addr, 15'h0000);
        end
        rst_n = 1'b1;
        drive(0, 0, 8'h00, 0, 0, "R7 idle after reset");
        drive(1, 0, 8'hAB, 0, 1, "R2 hi load, bit7 ignored");
        expect_model(15'h2B00, "R2 model");
        drive(0, 1, 8'h3E, 0, 1, "R3 lo load");
        drive(0, 0, 8'h00, 1, 1, "R4 page step");
        drive(0, 0, 8'h00, 1, 1, "R4 page wrap 63 to 0");
        expect_model(15'h2B00, "R4 model");
        repeat (5) drive(0, 0, 8'h00, 0, 0, "R7 hold");
        drive(0, 0, 8'h00, 1, 0, "R8 read continues from held");
        expect_model(15'h2B01, "R8 model");
        drive(1, 0, 8'h7F, 0, 0, "R2 hi load max");
        drive(0, 1, 8'hFF, 0, 0, "R3 lo load max");
        drive(0, 0, 8'h00, 1, 0, "R5 full wrap to zero");
        expect_model(15'h0000, "R5 model");
        drive(1, 0, 8'hFF, 0, 0, "R2 hi load 0xFF");
        drive(0, 1, 8'hFF, 0, 0, "R3 lo load");
        drive(0, 0, 8'h00, 1, 1, "R4 page wrap at top");
        expect_model(15'h7FC0, "R4 top model");
        drive(1, 1, 8'h15, 1, 0, "R6 hi over lo and step");
        drive(0, 1, 8'h99, 1, 1, "R6 lo over step");
        expect_model(15'h1599, "R6 model");
        for (int i = 0; i < 300; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            drive(r[0] & r[1] & r[2], r[1] & r[2], 8'($urandom), r[3] | r[0], r[2], "R6 random mix");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule